// File: doc/BRIEF.md
# SPI transmit buffer sequencer

This block is the send side of an SPI port. The host writes a word into a holding register. The block later copies that word into a separate shift register and sends it MSB first on a serial data output. A status bit tells the host when the holding register can take a new word. The block can act as bus master or as slave.

The cycle in which the copy happens, and the cycle in which the status bit rises, depend on the role and on the clock-phase bit:

- **Slave, phase 0:** the block copies only while the slave-select line is inactive.
- **Slave, phase 1, and master, phase 1:** the block copies as soon as the shifter is idle, and the status bit rises with the copy.
- **Master, phase 0:** the block copies at once, and the status bit rises only when the word has gone out.

As master, the block makes its own serial clock and select. It frames each word with select low, then keeps select high for a gap, so that a phase-0 slave has time to reload. As slave, it takes clock and select from pins and passes them through a two-stage synchronizer.

Top module: `spi_tx_seq`

## Requirements
- R1: After hardware reset, `tx_empty`=1, `overrun`=0, `cur_cpha`=1, `cur_cpol`=0, `sck_o`=0 and `ss_n_o`=1.
- R2: A host write (`wr_en`=1 at a clock edge) makes `tx_empty` read 0 after that edge.
- R3: A write while `tx_empty`=0 replaces the held word, so the replaced word is never sent. It also sets `overrun`=1, which stays set until a reset.
- R4: In slave mode with CPHA=0, the held word is copied only while the synchronized `ss_n_i` is 1. While `ss_n_i` stays 0, `tx_empty` stays 0, even after the previous word has finished.
- R5: In slave mode with CPHA=1, the held word is copied as soon as the shifter is idle, even while `ss_n_i` stays 0 across consecutive words.
- R6: In master mode with CPHA=0, a write is copied on the next edge, but `tx_empty` stays 0 through the whole frame. It returns to 1 after the last SCK edge of the word and before `ss_n_o` rises.
- R7: In every mode except master with CPHA=0, `tx_empty` becomes 1 on the edge after the copy. A word written during a frame therefore keeps it at 0 until the shifter empties.
- R8: Each word is `8*WORD_BYTES` bits long and is sent MSB first. The bits captured at the capture edges equal the written word.
- R9: In master mode, `sck_o` idles at the CPOL level. With CPHA=0, data is captured on the edge that leaves the idle level. With CPHA=1, data is captured on the edge that returns to it. CPOL=1 gives the same data as CPOL=0.
- R10: In master mode, `ss_n_o` goes low for exactly `2*8*WORD_BYTES` SCK transitions per word. Between words it is high for at least `HALF_DIV` clock cycles.
- R11: In slave mode, SCK transitions on `sck_i` while `ss_n_i`=1 do not disturb the loaded word.
- R12: A `sw_rst` pulse gives the same state as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous active-high software reset, same effect as `rst` |
| cfg_we | input | 1 | Loads the three configuration bits below |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of SCK |
| cfg_cpha | input | 1 | Clock phase select |
| cur_cpol | output | 1 | Current CPOL setting |
| cur_cpha | output | 1 | Current CPHA setting |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8*WORD_BYTES | Word to send |
| tx_empty | output | 1 | Holding register may be written |
| overrun | output | 1 | Sticky: a write replaced a word that had not been taken |
| sck_i | input | 1 | Serial clock from an external master (slave mode) |
| ss_n_i | input | 1 | Active-low select from an external master (slave mode) |
| sck_o | output | 1 | Generated serial clock (master mode), CPOL level otherwise |
| ss_n_o | output | 1 | Generated active-low select (master mode), 1 otherwise |
| sdo | output | 1 | Serial data out, MSB first |

## Verification
Master mode is run in all four CPOL/CPHA combinations. Single words show that phase 0 holds the status bit low across the frame while phase 1 releases it right after the copy. Back-to-back writes show that the pending word stays held until the shifter drains, and that each word gets its own select frame.

In slave mode, select is held low across a write to show that phase 0 refuses the copy until select goes high, while phase 1 copies with select still low. Clock toggles are sent while select is high to show they do not move the data. A triple write shows that only the last word of an overrun is sent. Data patterns with distinct MSBs and LSBs expose bit-order and off-by-one-bit faults.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    T_IDLE,
    T_SETUP,
    T_RUN,
    T_HOLD,
    T_GAP
  } tmr_state_e;
endpackage

// File: rtl/spi_tx_sync.sv
module spi_tx_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
    end else begin
      pipe_q[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_tx_mtimer.sv
module spi_tx_mtimer import spi_tx_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int HALF_DIV = 4,
  parameter int GAP_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cpol,
  input  logic start,
  output logic sck_q,
  output logic ss_n_q
);
  localparam int MAXC = (HALF_DIV > GAP_CYC) ? HALF_DIV : GAP_CYC;
  localparam int CW = $clog2(MAXC);
  localparam int TW = $clog2(2 * WORD_W);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);
  localparam logic [TW-1:0] TOG_LAST = TW'(2 * WORD_W - 1);

  tmr_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= T_IDLE;
      cnt_q  <= '0;
      tog_q  <= '0;
      sck_q  <= 1'b0;
      ss_n_q <= 1'b1;
    end else begin
      case (st_q)
        T_IDLE: begin
          sck_q  <= cpol;
          ss_n_q <= 1'b1;
          cnt_q  <= '0;
          if (start) begin
            st_q   <= T_SETUP;
            ss_n_q <= 1'b0;
          end
        end
        T_SETUP: begin
          if (cnt_q == HALF_LAST) begin
            cnt_q <= '0;
            tog_q <= '0;
            st_q  <= T_RUN;
          end else cnt_q <= cnt_q + 1'b1;
        end
        T_RUN: begin
          if (cnt_q == HALF_LAST) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
            if (tog_q == TOG_LAST) st_q <= T_HOLD;
            else tog_q <= tog_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        T_HOLD: begin
          if (cnt_q == HALF_LAST) begin
            cnt_q  <= '0;
            ss_n_q <= 1'b1;
            st_q   <= T_GAP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        T_GAP: begin
          if (cnt_q == GAP_LAST) begin
            cnt_q <= '0;
            st_q  <= T_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  // R9: a frame opens with the clock parked at its idle level
  p_frame_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ss_n_q) |-> (sck_q == cpol));

  // R10: select is released only after every clock transition of the word
  p_frame_len_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_n_q) |-> (tog_q == TOG_LAST));
endmodule

// File: rtl/spi_tx_shreg.sv
module spi_tx_shreg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  output logic              sdo,
  output logic              busy,
  output logic              done
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] BIT_LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic sck_prev_q, busy_q, done_q;
  logic lead, trail;

  assign lead  = ~ss_n & (sck_prev_q == cpol) & (sck != cpol);
  assign trail = ~ss_n & (sck_prev_q != cpol) & (sck == cpol);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      sck_prev_q <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      sck_prev_q <= sck;
      done_q     <= 1'b0;
      if (load) begin
        sh_q   <= load_data;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (lead && cpha && (cnt_q != '0)) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        if (trail) begin
          if (!cpha) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
          if (cnt_q == BIT_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sdo  = sh_q[WORD_W-1];
  assign busy = busy_q;
  assign done = done_q;

  // R11: with select inactive, only a copy may change the shifter
  p_hold_when_deselected_r11: assert property (@(posedge clk) disable iff (rst)
    (ss_n && !load) |=> $stable(sh_q));
endmodule

// File: rtl/spi_tx_seq.sv
module spi_tx_seq import spi_tx_pkg::*; #(
  parameter int WORD_BYTES = 2,
  parameter int HALF_DIV = 4,
  parameter int GAP_HALVES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sw_rst,
  input  logic                         cfg_we,
  input  logic                         cfg_master,
  input  logic                         cfg_cpol,
  input  logic                         cfg_cpha,
  output logic                         cur_cpol,
  output logic                         cur_cpha,
  input  logic                         wr_en,
  input  logic [BYTE_W*WORD_BYTES-1:0] wr_data,
  output logic                         tx_empty,
  output logic                         overrun,
  input  logic                         sck_i,
  input  logic                         ss_n_i,
  output logic                         sck_o,
  output logic                         ss_n_o,
  output logic                         sdo
);
  localparam int WORD_W = BYTE_W * WORD_BYTES;
  localparam int GAP_CYC = GAP_HALVES * HALF_DIV;

  logic rst_all;
  assign rst_all = rst | sw_rst;

  logic master_q, cpol_q, cpha_q;
  always_ff @(posedge clk) begin
    if (rst_all) begin
      master_q <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b1;
    end else if (cfg_we) begin
      master_q <= cfg_master;
      cpol_q   <= cfg_cpol;
      cpha_q   <= cfg_cpha;
    end
  end

  logic [1:0] pin_s;
  spi_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst_all), .din({sck_i, ss_n_i}), .dout(pin_s)
  );

  logic sh_busy, sh_done, load, set_flag, m0;
  logic tmr_sck, tmr_ss_n, sck_eff, ss_eff_n;
  logic [WORD_W-1:0] hold_q;
  logic hold_full, empty_q, ovr_q;

  assign m0       = master_q & ~cpha_q;
  assign load     = hold_full & ~sh_busy & (master_q | cpha_q | ss_eff_n);
  assign set_flag = m0 ? sh_done : load;
  assign sck_eff  = master_q ? tmr_sck  : pin_s[1];
  assign ss_eff_n = master_q ? tmr_ss_n : pin_s[0];

  spi_tx_mtimer #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) u_tmr (
    .clk(clk), .rst(rst_all), .cpol(cpol_q), .start(master_q & sh_busy),
    .sck_q(tmr_sck), .ss_n_q(tmr_ss_n)
  );

  spi_tx_shreg #(.WORD_W(WORD_W)) u_shr (
    .clk(clk), .rst(rst_all), .cpha(cpha_q), .cpol(cpol_q),
    .sck(sck_eff), .ss_n(ss_eff_n), .load(load), .load_data(hold_q),
    .sdo(sdo), .busy(sh_busy), .done(sh_done)
  );

  always_ff @(posedge clk) begin
    if (rst_all) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      empty_q   <= 1'b1;
      ovr_q     <= 1'b0;
    end else if (wr_en) begin
      hold_q    <= wr_data;
      hold_full <= 1'b1;
      empty_q   <= 1'b0;
      if (!empty_q) ovr_q <= 1'b1;
    end else begin
      if (load) hold_full <= 1'b0;
      if (set_flag) empty_q <= 1'b1;
    end
  end

  assign tx_empty = empty_q;
  assign overrun  = ovr_q;
  assign cur_cpol = cpol_q;
  assign cur_cpha = cpha_q;
  assign sck_o    = master_q ? tmr_sck  : cpol_q;
  assign ss_n_o   = master_q ? tmr_ss_n : 1'b1;

  // R2: a host write always leaves the empty flag low
  p_wr_clear_r2: assert property (@(posedge clk) disable iff (rst_all)
    wr_en |=> !empty_q);

  // R3: writing over an untaken word raises the sticky status
  p_ovr_set_r3: assert property (@(posedge clk) disable iff (rst_all)
    (wr_en && !empty_q) |=> ovr_q);

  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (rst_all)
    ovr_q |=> ovr_q);

  // R4: a phase-0 slave only starts a word that was copied with select high
  p_s0_wait_r4: assert property (@(posedge clk) disable iff (rst_all)
    ($rose(sh_busy) && $past(!master_q && !cpha_q)) |-> $past(ss_eff_n));

  // R6: phase-0 master raises the flag only right after the word completes
  p_m0_flag_end_r6: assert property (@(posedge clk) disable iff (rst_all)
    ($rose(empty_q) && $past(m0)) |-> $past(sh_done));

  // R7: other modes raise the flag on the edge after the copy
  p_copy_flag_r7: assert property (@(posedge clk) disable iff (rst_all)
    (load && !wr_en && !m0) |=> empty_q);
endmodule

// File: tb/spi_tx_seq_bench.sv
`timescale 1ns/1ps
module spi_tx_seq_bench;
  localparam int W = 16;
  localparam int HALF = 4;
  localparam int SHALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, sw_rst = 1'b0;
  logic cfg_we = 1'b0, cfg_master = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b1;
  logic cur_cpol, cur_cpha;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic tx_empty, overrun;
  logic sck_i = 1'b0, ss_n_i = 1'b1;
  logic sck_o, ss_n_o, sdo;

  always #4 clk = ~clk;

  spi_tx_seq #(.WORD_BYTES(2), .HALF_DIV(HALF), .GAP_HALVES(2), .SYNC_STAGES(2)) u_spi_tx_seq (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .cfg_we(cfg_we), .cfg_master(cfg_master),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cur_cpol(cur_cpol), .cur_cpha(cur_cpha),
    .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty), .overrun(overrun),
    .sck_i(sck_i), .ss_n_i(ss_n_i), .sck_o(sck_o), .ss_n_o(ss_n_o), .sdo(sdo)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic tb_master = 0, tb_cpol = 0, tb_cpha = 1;
  logic [W-1:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmp_word(input string req, input logic [W-1:0] got);
    if (exp_q.size() == 0) begin
      n_tests++; n_fail++;
      $display("FAIL %s: actual %h expected <none queued>", req, got);
    end else chk(req, got, exp_q.pop_front());
  endtask

  task automatic host_write(input logic [W-1:0] d, input bit sent);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    if (sent) exp_q.push_back(d);
    @(negedge clk); wr_en = 1'b0;
    chk("R2", tx_empty, 0);
  endtask

  task automatic configure(input logic m, input logic pol, input logic pha);
    @(negedge clk);
    cfg_we = 1'b1; cfg_master = m; cfg_cpol = pol; cfg_cpha = pha;
    tb_master = m; tb_cpol = pol; tb_cpha = pha;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_frames();
    while (exp_q.size() != 0) @(negedge clk);
    while (!ss_n_o) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic slave_word(input string req);
    logic [W-1:0] got = '0;
    for (int i = 0; i < W; i++) begin
      repeat (SHALF) @(negedge clk);
      if (!tb_cpha) got = {got[W-2:0], sdo};
      sck_i = ~tb_cpol;
      repeat (SHALF) @(negedge clk);
      if (tb_cpha) got = {got[W-2:0], sdo};
      sck_i = tb_cpol;
    end
    repeat (SHALF) @(negedge clk);
    cmp_word(req, got);
  endtask

  // scoreboard monitor for master frames
  int mon_bits = 0, gap = 0;
  bit seen = 0;
  logic prev_sck = 1'b0, prev_ss = 1'b1, cap;
  logic [W-1:0] mon_word = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !sw_rst) begin
        if (prev_ss && !ss_n_o) begin
          if (seen) chk("R10", 32'(gap >= HALF), 1);
          mon_bits = 0;
        end
        if (!ss_n_o && (sck_o != prev_sck)) begin
          cap = tb_cpha ? (sck_o == tb_cpol) : (sck_o != tb_cpol);
          if (cap) begin
            mon_word = {mon_word[W-2:0], sdo};
            mon_bits++;
            if (mon_bits == W) cmp_word(tb_cpol ? "R9" : "R8", mon_word);
          end
        end
        if (!prev_ss && ss_n_o) begin
          chk("R10", mon_bits, W);
          seen = 1; gap = 0;
        end else if (ss_n_o) gap++;
      end
      prev_sck = sck_o; prev_ss = ss_n_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", tx_empty, 1); chk("R1", overrun, 0);
    chk("R1", cur_cpha, 1); chk("R1", cur_cpol, 0);
    chk("R1", sck_o, 0);    chk("R1", ss_n_o, 1);

    // master, phase 1: copy and flag right after write; pending word held
    configure(1, 0, 1);
    host_write(16'hA53C, 1);
    @(negedge clk); chk("R7", tx_empty, 1);
    host_write(16'h0FF1, 1);
    while (ss_n_o) @(negedge clk);
    chk("R7", tx_empty, 0);
    while (!ss_n_o) @(negedge clk);
    chk("R7", tx_empty, 1);
    wait_frames();

    // master, phase 0: flag held low for the whole frame
    configure(1, 0, 0);
    host_write(16'h8001, 1);
    @(negedge clk); chk("R6", tx_empty, 0);
    while (ss_n_o) @(negedge clk);
    chk("R6", tx_empty, 0);
    while (!ss_n_o) @(negedge clk);
    chk("R6", tx_empty, 1);
    wait_frames();

    // master, CPOL=1 both phases
    configure(1, 1, 0);
    @(negedge clk); chk("R9", sck_o, 1);
    host_write(16'h7E5A, 1);
    wait_frames();
    configure(1, 1, 1);
    host_write(16'hC3A5, 1);
    host_write(16'h1234, 1);
    wait_frames();

    // slave, phase 0
    configure(0, 0, 0);
    sck_i = 1'b0; ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    host_write(16'h5AC3, 1);
    repeat (20) @(negedge clk); chk("R4", tx_empty, 0);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk); chk("R4", tx_empty, 1);
    repeat (3) begin
      sck_i = 1'b1; repeat (SHALF) @(negedge clk);
      sck_i = 1'b0; repeat (SHALF) @(negedge clk);
    end
    host_write(16'h3C96, 1);
    ss_n_i = 1'b0; repeat (SHALF) @(negedge clk);
    slave_word("R11");
    repeat (20) @(negedge clk); chk("R4", tx_empty, 0);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk); chk("R4", tx_empty, 1);
    ss_n_i = 1'b0; repeat (SHALF) @(negedge clk);
    slave_word("R4");
    ss_n_i = 1'b1; repeat (SHALF) @(negedge clk);

    // slave, phase 1, CPOL=1: select held low across words
    sck_i = 1'b1;
    configure(0, 1, 1);
    ss_n_i = 1'b0; repeat (4) @(negedge clk);
    host_write(16'hE718, 1);
    repeat (6) @(negedge clk); chk("R5", tx_empty, 1);
    host_write(16'h2B4D, 1);
    slave_word("R8");
    repeat (SHALF) @(negedge clk); chk("R5", tx_empty, 1);
    slave_word("R5");
    chk("R3", overrun, 0);

    // overrun: third write replaces the held second word
    host_write(16'h1111, 1);
    repeat (3) @(negedge clk);
    host_write(16'h2222, 0);
    host_write(16'h3333, 1);
    chk("R3", overrun, 1);
    slave_word("R8");
    repeat (SHALF) @(negedge clk);
    slave_word("R3");
    chk("R3", overrun, 1);
    ss_n_i = 1'b1; repeat (SHALF) @(negedge clk);

    // software reset
    configure(1, 1, 0);
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    chk("R12", cur_cpha, 1); chk("R12", cur_cpol, 0);
    chk("R12", overrun, 0);  chk("R12", tx_empty, 1);
    chk("R12", ss_n_o, 1);   chk("R12", sck_o, 0);
    chk("R8", exp_q.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule